// File: doc/BRIEF.md
# Event and Semaphore Aliased Register Bank

This block is a memory-mapped bank of single-bit event flags and counting semaphores. It sits behind a 1 MiB register region. The same semaphore storage can be reached through several 1 KiB windows. The window an access lands in selects the operation: plain read, load, add, subtract with a floor at zero, or add one. Software can therefore bump or drain a semaphore with one bus write and no read-modify-write sequence. The operation is carried entirely by the address.

The bus is word addressed. `busAddr` is the byte offset inside the region divided by four. A request is presented by raising `busSel` for one cycle. `busReady` answers in the next cycle, and `busRdata` carries the read result in that same cycle. Each entry is one 32-bit word on a 4-byte stride, so 256 entries fill exactly one 1 KiB window. A window may be left unpopulated: the add-one window at byte 0x2000 exists only when the `HAS_CINC` parameter is set, which it is by default.

Top module: `evsem_bank`

## Requirements
- R1: After reset every event flag and every semaphore count is zero, and `busReady` is low.
- R2: `busReady` is high in the cycle after each cycle with `busSel` high, and low otherwise. Read data is valid while `busReady` is high.
- R3: The event window at byte offset 0x000 + 4·i maps to event i. A write stores bit 0 of the write data as the flag. A read returns the flag in bit 0 with bits 31:1 at zero.
- R4: A write to the load window at byte 0x1400 + 4·i sets semaphore i to the write data.
- R5: A read at byte 0x1000 + 4·i returns the count of semaphore i. A read through the load, add or subtract windows (0x1400, 0x1800, 0x1C00 + 4·i) returns the same count and changes nothing.
- R6: A write to the add window at byte 0x1800 + 4·i adds the write data to semaphore i. The result saturates at 0xFFFFFFFF.
- R7: A write to the subtract window at byte 0x1C00 + 4·i subtracts the write data from semaphore i. The result saturates at zero.
- R8: A write to the read window at byte 0x1000 + 4·i has no effect.
- R9: An access to an unmapped offset, for example 0x0400, 0x2400 or 0xFFFFC, reads as zero. A write there changes no event and no semaphore.
- R10: When `HAS_CINC` is set, a write to byte 0x2000 + 4·i adds one to semaphore i whatever the data, saturating at 0xFFFFFFFF. A read there returns the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Request strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 18 | Word address (byte offset / 4) inside the 1 MiB region |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Access completion, one cycle after busSel |

## Verification
The bench drives the add window past the top of the count range. A design that wraps there would return a small value instead of 0xFFFFFFFF. It also subtracts more than the stored count. A design without the zero floor would read back a huge wrapped value. Alias reads through the load, add and subtract windows are checked for leaving the count untouched, which catches a decoder that treats any access to those windows as a write. Writes to the read window and to unmapped offsets must leave event 0 and semaphore 0 unchanged. A decoder that ignores the high window bits would corrupt them.

// File: rtl/evsem_pkg.sv
package evsem_pkg;
  // Entries per 1 KiB window at a 4-byte stride.
  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EVT,
    OP_SEM_RD,
    OP_SEM_SET,
    OP_SEM_ADD,
    OP_SEM_SUB,
    OP_SEM_ONE
  } semOp_t;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    semOp_t           op;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/evsem_ctrl.sv
module evsem_ctrl
  import evsem_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int NUM_EVT  = 256,
  parameter int NUM_SEM  = 256,
  parameter bit HAS_CINC = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe,
  output logic              busReady
);
  localparam int WIN_W = ADDR_W - IDX_W;
  // Window numbers in 1 KiB units; these positions define the operations.
  localparam logic [WIN_W-1:0] WIN_EVT  = WIN_W'(0);
  localparam logic [WIN_W-1:0] WIN_SRD  = WIN_W'(4);
  localparam logic [WIN_W-1:0] WIN_SSET = WIN_W'(5);
  localparam logic [WIN_W-1:0] WIN_SADD = WIN_W'(6);
  localparam logic [WIN_W-1:0] WIN_SSUB = WIN_W'(7);
  localparam logic [WIN_W-1:0] WIN_CINC = WIN_W'(8);

  logic [WIN_W-1:0] win;
  logic [IDX_W-1:0] idx;
  logic             evtOk, semOk, cincHit;
  semOp_t           op;

  assign win   = busAddr[ADDR_W-1:IDX_W];
  assign idx   = busAddr[IDX_W-1:0];
  assign evtOk = (int'(idx) < NUM_EVT);
  assign semOk = (int'(idx) < NUM_SEM);

  generate
    if (HAS_CINC) begin : g_cinc
      assign cincHit = (win == WIN_CINC) && semOk;
    end else begin : g_nocinc
      assign cincHit = 1'b0;
    end
  endgenerate

  always_comb begin
    op = OP_NONE;
    if (win == WIN_EVT && evtOk)       op = OP_EVT;
    else if (semOk) begin
      unique case (win)
        WIN_SRD:  op = OP_SEM_RD;
        WIN_SSET: op = OP_SEM_SET;
        WIN_SADD: op = OP_SEM_ADD;
        WIN_SSUB: op = OP_SEM_SUB;
        default:  op = cincHit ? OP_SEM_ONE : OP_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.op   = op;
    strobe.idx  = idx;
    strobe.rdEn = busSel && !busWe;
    strobe.wrEn = busSel && busWe && (op != OP_NONE) && (op != OP_SEM_RD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) busReady <= 1'b0;
    else       busReady <= busSel;
  end

  a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rstN)
    busSel |=> busReady);
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> !busReady);
  // R8: the read window never produces a write strobe
  a_r8_rd_window_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && win == WIN_SRD) |-> !strobe.wrEn);
endmodule

// File: rtl/evsem_dp.sv
module evsem_dp
  import evsem_pkg::*;
#(
  parameter int NUM_EVT = 256,
  parameter int NUM_SEM = 256,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData
);
  localparam int EVT_IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam int SEM_IW = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

  logic [NUM_EVT-1:0] evtFlag;
  logic [CNT_W-1:0]   semCnt [NUM_SEM];

  logic [EVT_IW-1:0] evtIdx;
  logic [SEM_IW-1:0] semIdx;
  logic [CNT_W-1:0]  cur, wVal, addSat, subSat, oneSat, nextCnt;
  logic [CNT_W:0]    sum;

  assign evtIdx = strobe.idx[EVT_IW-1:0];
  assign semIdx = strobe.idx[SEM_IW-1:0];
  assign cur    = semCnt[semIdx];
  assign wVal   = wData[CNT_W-1:0];
  assign sum    = {1'b0, cur} + {1'b0, wVal};
  assign addSat = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  assign subSat = (cur > wVal) ? (cur - wVal) : '0;
  assign oneSat = (&cur) ? cur : (cur + CNT_W'(1));

  always_comb begin
    unique case (strobe.op)
      OP_SEM_SET: nextCnt = wVal;
      OP_SEM_ADD: nextCnt = addSat;
      OP_SEM_SUB: nextCnt = subSat;
      OP_SEM_ONE: nextCnt = oneSat;
      default:    nextCnt = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtFlag <= '0;
      for (int i = 0; i < NUM_SEM; i++) semCnt[i] <= '0;
      rData <= '0;
    end else begin
      if (strobe.wrEn) begin
        if (strobe.op == OP_EVT) evtFlag[evtIdx] <= wData[0];
        else                     semCnt[semIdx]  <= nextCnt;
      end
      if (strobe.rdEn) begin
        unique case (strobe.op)
          OP_NONE: rData <= '0;
          OP_EVT:  rData <= DATA_W'(evtFlag[evtIdx]);
          default: rData <= DATA_W'(cur);
        endcase
      end else begin
        rData <= '0;
      end
    end
  end

  a_r7_sub_floor: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.op == OP_SEM_SUB && cur <= wVal)
      |=> semCnt[$past(semIdx)] == '0);
  a_r6_add_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.op == OP_SEM_ADD)
      |=> semCnt[$past(semIdx)] >= $past(cur));
  a_r5_read_no_side_effect: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.op != OP_NONE && strobe.op != OP_EVT)
      |=> semCnt[$past(semIdx)] == $past(cur));
  a_r3_evt_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.op == OP_EVT) |=> rData[DATA_W-1:1] == '0);
endmodule

// File: rtl/evsem_bank.sv
module evsem_bank
  import evsem_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 256,
  parameter int NUM_SEM  = 256,
  parameter bit HAS_CINC = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady
);
  strobe_t strobe;

  evsem_ctrl #(
    .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .NUM_SEM(NUM_SEM), .HAS_CINC(HAS_CINC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .strobe(strobe), .busReady(busReady)
  );

  evsem_dp #(
    .NUM_EVT(NUM_EVT), .NUM_SEM(NUM_SEM), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wData(busWdata), .rData(busRdata)
  );

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && strobe.op == OP_NONE) |=> busRdata == '0);
endmodule

// File: tb/evsem_bank_tb.sv
module evsem_bank_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWe;
  logic [17:0] busAddr;
  logic [31:0] busWdata, busRdata;
  logic        busReady;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  evsem_bank u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic doWrite(logic [19:0] byteOff, logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = byteOff[19:2]; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic doRead(logic [19:0] byteOff, output logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = byteOff[19:2];
    @(negedge clk);
    data = busRdata;
    busSel = 1'b0;
  endtask

  task automatic readCheck(string req, logic [19:0] byteOff, logic [31:0] exp);
    logic [31:0] v;
    doRead(byteOff, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    check("R1 ready after reset", {31'b0, busReady}, 32'h0);
    readCheck("R1 event 5 cleared", 20'h014, 32'h0);
    readCheck("R1 sem 7 cleared", 20'h101C, 32'h0);
  endtask

  task automatic t_ready();
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = 18'h0;
    @(negedge clk);
    check("R2 ready after select", {31'b0, busReady}, 32'h1);
    busSel = 1'b0;
    @(negedge clk);
    check("R2 ready low when idle", {31'b0, busReady}, 32'h0);
  endtask

  task automatic t_events();
    doWrite(20'h028, 32'h3);
    readCheck("R3 event 10 set by bit0", 20'h028, 32'h1);
    doWrite(20'h028, 32'h2);
    readCheck("R3 event 10 cleared, bit1 ignored", 20'h028, 32'h0);
    doWrite(20'h3FC, 32'hFFFF_FFFF);
    readCheck("R3 event 255 flag only in bit0", 20'h3FC, 32'h1);
    readCheck("R3 event 254 untouched", 20'h3F8, 32'h0);
  endtask

  task automatic t_set();
    doWrite(20'h140C, 32'h1234);
    readCheck("R4 sem 3 loaded", 20'h100C, 32'h1234);
  endtask

  task automatic t_aliasRead();
    readCheck("R5 read via load window", 20'h140C, 32'h1234);
    readCheck("R5 read via add window", 20'h180C, 32'h1234);
    readCheck("R5 read via subtract window", 20'h1C0C, 32'h1234);
    readCheck("R5 count unchanged after alias reads", 20'h100C, 32'h1234);
  endtask

  task automatic t_add();
    doWrite(20'h180C, 32'h10);
    readCheck("R6 add 0x10", 20'h100C, 32'h1244);
    doWrite(20'h1410, 32'hFFFF_FFF0);
    doWrite(20'h1810, 32'h20);
    readCheck("R6 add saturates at max", 20'h1010, 32'hFFFF_FFFF);
  endtask

  task automatic t_sub();
    doWrite(20'h1C0C, 32'h44);
    readCheck("R7 subtract 0x44", 20'h100C, 32'h1200);
    doWrite(20'h1C0C, 32'h5000);
    readCheck("R7 subtract floors at zero", 20'h100C, 32'h0);
  endtask

  task automatic t_readOnly();
    doWrite(20'h1414, 32'h7);
    doWrite(20'h1014, 32'h99);
    readCheck("R8 write to read window ignored", 20'h1014, 32'h7);
  endtask

  task automatic t_unmapped();
    doWrite(20'h0400, 32'h1);
    doWrite(20'h2400, 32'h55);
    doWrite(20'hFFFFC, 32'h66);
    readCheck("R9 unmapped 0x0400 reads zero", 20'h0400, 32'h0);
    readCheck("R9 unmapped 0x2400 reads zero", 20'h2400, 32'h0);
    readCheck("R9 unmapped 0xFFFFC reads zero", 20'hFFFFC, 32'h0);
    readCheck("R9 event 0 untouched", 20'h000, 32'h0);
    readCheck("R9 sem 0 untouched", 20'h1000, 32'h0);
  endtask

  task automatic t_cinc();
    doWrite(20'h1424, 32'h5);
    doWrite(20'h2024, 32'h100);
    readCheck("R10 add-one ignores data", 20'h1024, 32'h6);
    readCheck("R10 read via add-one window", 20'h2024, 32'h6);
    doWrite(20'h1428, 32'hFFFF_FFFF);
    doWrite(20'h2028, 32'h0);
    readCheck("R10 add-one saturates", 20'h1028, 32'hFFFF_FFFF);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; busSel = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ready();
    t_events();
    t_set();
    t_aliasRead();
    t_add();
    t_sub();
    t_readOnly();
    t_unmapped();
    t_cinc();
    repeat (2) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule